// File: doc/BRIEF.md
# Vblank-Synchronized Selectable Clock Divider

This block turns a fast input clock into a clock-enable stream. A small divider with four permitted ratios comes first. A fixed halving stage follows it, and the halving stage drives `out_en` high for one cycle on each final divided edge. Downstream logic gates on `out_en` and never switches a real clock.

Software asks for a new ratio by pulsing `sel_wr` with a 2-bit code. The request is held until the next `vblank_start` pulse. At that pulse the request is armed. The switch itself happens on the next `out_en` cycle, so the one active display pipe sees only complete output periods of the old ratio and then of the new one.

A request state machine has four states:
- `REQ_IDLE`: nothing is waiting.
- `REQ_HELD`: a code waits for vblank.
- `REQ_ARMED`: a code waits for the period boundary.
- `REQ_ARMED_HELD`: one code is armed and a newer code is held behind it.

Its transitions are:
- *write* (IDLE→HELD, ARMED→ARMED_HELD).
- *vblank promote* (HELD→ARMED, or HELD→ARMED_HELD when a write lands in the same cycle).
- *boundary apply* (ARMED→IDLE or →HELD; ARMED_HELD→HELD, or →ARMED / →ARMED_HELD when vblank coincides).

With the `BYPASS` parameter set, the selectable stage is removed and only the halving stage remains.

Top module: `frame_sync_clkdiv`

## Requirements
- R1: After reset, `active_sel` is 00 and `pending` is 0. `out_en` is 0 in the first cycle after reset release and first goes high in the second cycle.
- R2: The code in `active_sel` sets the spacing of the `out_en` pulses in input cycles: 00 gives 2, 01 gives 3, 10 gives 4, 11 gives 8.
- R3: With code 01, the inner divider alternates slots of 1 and 2 input cycles, starting with a 1-cycle slot after a switch. The first `out_en` after a switch therefore comes 2 cycles after the switch cycle. For the other codes it comes 1 less than the R2 spacing after the switch cycle.
- R4: A `sel_wr` pulse sets `pending` from the next cycle. `active_sel` does not change while no `vblank_start` arrives.
- R5: A `vblank_start` while a code is held arms that code. It becomes `active_sel` in the cycle after the next `out_en` cycle, and the divider restarts at that point. `pending` clears at the same time, unless a newer code is waiting.
- R6: A `sel_wr` while a request waits replaces the held code, and `pending` stays 1.
- R7: When `vblank_start` and `sel_wr` arrive in the same cycle, the previously held code is armed and the newly written code is held for a later vblank.
- R8: A `vblank_start` while no code is held changes neither `pending` nor `active_sel` nor the `out_en` spacing.
- R9: With `BYPASS` = 1, `out_en` pulses every 2 cycles whatever is written. `active_sel` and `pending` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for `sel_code` |
| sel_code | input | 2 | Requested ratio code (00 ÷1, 01 ÷1.5, 10 ÷2, 11 ÷4) |
| vblank_start | input | 1 | Start-of-vblank pulse of the active pipe |
| out_en | output | 1 | One-cycle enable per final divided edge |
| pending | output | 1 | A written code is not yet in effect |
| active_sel | output | 2 | Code currently driving the divider |

## Verification
`pending` is due one cycle after the `sel_wr` edge. `active_sel` and the divider restart are due one cycle after the `out_en` cycle that follows an arming vblank. The first new-ratio `out_en` then lands 1, 2, 3 or 7 cycles later. The bench keeps a behavioural model that applies each edge's inputs in the order boundary, then vblank, then write. It compares all three outputs on every falling edge, so each result is checked in exactly the cycle it is due. Directed sections cover coincident vblank and write, vblank on a boundary, and vblank with nothing held. A pseudo-random stretch follows, and a second instance with `BYPASS` = 1 runs alongside.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int SLOT_MAX = 4;
    localparam int CNT_W    = $clog2(SLOT_MAX);
    localparam int LEN_W    = $clog2(SLOT_MAX + 1);

    typedef enum logic [1:0] {
        REQ_IDLE       = 2'd0,
        REQ_HELD       = 2'd1,
        REQ_ARMED      = 2'd2,
        REQ_ARMED_HELD = 2'd3
    } req_state_e;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_1P5 = 2'b01,
        DIV_2   = 2'b10,
        DIV_4   = 2'b11
    } div_sel_e;

    // Inner slot length in input cycles; the 1.5 ratio alternates 1 and 2.
    function automatic logic [LEN_W-1:0] slot_len(div_sel_e sel, logic half);
        logic [LEN_W-1:0] len;
        unique case (sel)
            DIV_1:   len = LEN_W'(1);
            DIV_1P5: len = half ? LEN_W'(2) : LEN_W'(1);
            DIV_2:   len = LEN_W'(2);
            DIV_4:   len = LEN_W'(4);
            default: len = LEN_W'(1);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/fsc_req_fsm.sv
module fsc_req_fsm
    import fsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] code,
    input  logic       vblank,
    input  logic       boundary,
    output logic [1:0] act_sel,
    output logic       pending,
    output logic       restart
);

    req_state_e state, state_nxt;
    div_sel_e   held_q, held_d;
    div_sel_e   arm_q, arm_d;
    div_sel_e   act_q, act_d;
    logic       apply;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= DIV_1;
            arm_q  <= DIV_1;
            act_q  <= DIV_1;
        end else begin
            held_q <= held_d;
            arm_q  <= arm_d;
            act_q  <= act_d;
        end
    end

    // Next state and data; order within a cycle is boundary, vblank, write
    always_comb begin
        state_nxt = state;
        held_d    = wr ? div_sel_e'(code) : held_q;
        arm_d     = arm_q;
        act_d     = act_q;
        apply     = 1'b0;
        unique case (state)
            REQ_IDLE: begin
                if (wr) state_nxt = REQ_HELD;
            end
            REQ_HELD: begin
                if (vblank) begin
                    arm_d     = held_q;
                    state_nxt = wr ? REQ_ARMED_HELD : REQ_ARMED;
                end
            end
            REQ_ARMED: begin
                if (boundary) begin
                    apply     = 1'b1;
                    act_d     = arm_q;
                    state_nxt = wr ? REQ_HELD : REQ_IDLE;
                end else if (wr) begin
                    state_nxt = REQ_ARMED_HELD;
                end
            end
            REQ_ARMED_HELD: begin
                if (boundary) begin
                    apply = 1'b1;
                    act_d = arm_q;
                    if (vblank) begin
                        arm_d     = held_q;
                        state_nxt = wr ? REQ_ARMED_HELD : REQ_ARMED;
                    end else begin
                        state_nxt = REQ_HELD;
                    end
                end
            end
            default: state_nxt = REQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending = (state != REQ_IDLE);
        restart = apply;
        act_sel = act_q;
    end

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !boundary) |=> pending); // R6
    AST_ACT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> $past(boundary)); // R5
    AST_VB_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_HELD && vblank) |=> (state == REQ_ARMED || state == REQ_ARMED_HELD)); // R5
    AST_IDLE_VB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REQ_IDLE && vblank && !wr) |=> (state == REQ_IDLE)); // R8

endmodule

// File: rtl/fsc_sel_divider.sv
module fsc_sel_divider
    import fsc_pkg::*;
#(
    parameter bit BYPASS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       restart,
    output logic       out_en
);

    logic [CNT_W-1:0] cnt;
    logic             half;
    logic             phase;
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] last;
    logic             tick;

    generate
        if (BYPASS) begin : g_bypass
            assign len = LEN_W'(1);
        end else begin : g_select
            assign len = slot_len(div_sel_e'(sel), half);
        end
    endgenerate

    assign last   = CNT_W'(len - LEN_W'(1));
    assign tick   = (cnt == last);
    assign out_en = tick & phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            half  <= 1'b0;
            phase <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            half  <= 1'b0;
            phase <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
            if (!BYPASS && div_sel_e'(sel) == DIV_1P5) half <= ~half;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last); // R2
    AST_OUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> !out_en); // R2
    AST_RESTART_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> out_en); // R5

endmodule

// File: rtl/frame_sync_clkdiv.sv
module frame_sync_clkdiv #(
    parameter bit BYPASS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_code,
    input  logic       vblank_start,
    output logic       out_en,
    output logic       pending,
    output logic [1:0] active_sel
);

    logic restart;

    generate
        if (BYPASS) begin : g_fixed_only
            assign active_sel = 2'b00;
            assign pending    = 1'b0;
            assign restart    = 1'b0;
        end else begin : g_requests
            fsc_req_fsm i_req (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (sel_wr),
                .code     (sel_code),
                .vblank   (vblank_start),
                .boundary (out_en),
                .act_sel  (active_sel),
                .pending  (pending),
                .restart  (restart)
            );

            AST_WR_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
                sel_wr |=> pending); // R4
        end
    endgenerate

    fsc_sel_divider #(.BYPASS(BYPASS)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (active_sel),
        .restart (restart),
        .out_en  (out_en)
    );

    AST_SEL_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sel != $past(active_sel)) |-> $past(out_en)); // R5

endmodule

// File: tb/test_frame_sync_clkdiv.sv
`timescale 1ns/1ps
module test_frame_sync_clkdiv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_code = 2'b00;
    logic       vblank_start = 1'b0;
    logic       out_en, pending;
    logic [1:0] active_sel;
    logic       b_out_en, b_pending;
    logic [1:0] b_active_sel;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    frame_sync_clkdiv i_frame_sync_clkdiv (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_code(sel_code),
        .vblank_start(vblank_start), .out_en(out_en), .pending(pending),
        .active_sel(active_sel)
    );

    frame_sync_clkdiv #(.BYPASS(1'b1)) i_frame_sync_clkdiv_byp (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_code(sel_code),
        .vblank_start(vblank_start), .out_en(b_out_en), .pending(b_pending),
        .active_sel(b_active_sel)
    );

    // Behavioural reference model
    int m_sel, m_left, m_odd, m_half;
    int has_held, held, has_arm, arm;
    int b_odd;

    function automatic int mlen(int s, int h);
        case (s)
            0: return 1;
            1: return h ? 2 : 1;
            2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic check(string what, int act, int exp, string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int exp_out, tick;
        tick    = (m_left == 1);
        exp_out = (tick && m_odd) ? 1 : 0;
        check("out_en", int'(out_en), exp_out, cur_req);
        check("pending", int'(pending), (has_held || has_arm) ? 1 : 0, cur_req);
        check("active_sel", int'(active_sel), m_sel, cur_req);
        check("bypass out_en", int'(b_out_en), b_odd, "R9");
        check("bypass pending", int'(b_pending), 0, "R9");
        check("bypass active_sel", int'(b_active_sel), 0, "R9");
        if (!rst_n) begin
            m_sel = 0; m_left = 1; m_odd = 0; m_half = 0;
            has_held = 0; held = 0; has_arm = 0; arm = 0; b_odd = 0;
        end else begin
            int fresh;
            fresh = 0;
            if (exp_out && has_arm) begin
                m_sel = arm; has_arm = 0; fresh = 1;
            end
            if (vblank_start && has_held && !has_arm) begin
                arm = held; has_arm = 1; has_held = 0;
            end
            if (sel_wr) begin
                held = int'(sel_code); has_held = 1;
            end
            if (fresh) begin
                m_odd = 0; m_half = 0; m_left = mlen(m_sel, 0);
            end else if (tick) begin
                m_odd = 1 - m_odd;
                if (m_sel == 1) m_half = 1 - m_half;
                m_left = mlen(m_sel, m_half);
            end else begin
                m_left = m_left - 1;
            end
            b_odd = 1 - b_odd;
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write(logic [1:0] c, logic vb);
        sel_wr = 1'b1; sel_code = c; vblank_start = vb;
        cyc();
        sel_wr = 1'b0; vblank_start = 1'b0;
    endtask

    task automatic vblank();
        vblank_start = 1'b1;
        cyc();
        vblank_start = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        cur_req = "R1";
        cyc(4);
        rst_n = 1'b1;
        cyc(12);
        cur_req = "R8";
        vblank();
        cyc(6);
        cur_req = "R4";
        write(2'b11, 1'b0);
        cyc(15);
        cur_req = "R6";
        write(2'b10, 1'b0);
        cyc(5);
        cur_req = "R5";
        vblank();
        cyc(25);
        cur_req = "R7";
        write(2'b11, 1'b0);
        cyc(3);
        write(2'b01, 1'b1);
        cyc(30);
        vblank();
        cyc(30);
        cur_req = "R3";
        write(2'b10, 1'b0);
        vblank();
        cyc(20);
        write(2'b00, 1'b0);
        vblank();
        cyc(20);
        cur_req = "R2";
        for (int c = 0; c < 4; c++) begin
            write(2'(c), 1'b0);
            cyc(2);
            vblank();
            cyc(40);
        end
        cur_req = "R5";
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel_code     = lfsr[1:0];
            sel_wr       = (lfsr[6:3] == 4'd0);
            vblank_start = (lfsr[11:8] == 4'd5);
            cyc();
        end
        sel_wr = 1'b0; vblank_start = 1'b0;
        cyc(10);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule